// File: doc/BRIEF.md
# Receive Descriptor Ring Write-Back Engine

This block takes an incoming frame whose total byte count is known up front and stores it in host memory buffers described by a ring of 16-byte receive descriptors. Software programs the ring base address, the ring length in bytes, the head and tail indices and a control word holding the receive enable, a 2-bit buffer-size code and a size-extension flag. When a frame starts, the engine fetches the descriptor at the head, streams as many 32-bit data words into that buffer as the buffer size allows, writes back the byte count and a status word, advances the head, and repeats until the frame is stored or the ring runs out of free descriptors.

All memory traffic, descriptor reads as well as data and write-back writes, goes through one request/acknowledge port. Frame data arrives on a valid/ready word stream; words that cannot be stored (a dropped frame or the tail of an overrun frame) are still drained from the stream. Two single-cycle event outputs report a completed frame and a ring overrun.

Top module: `rx_ring_wb`

## Requirements
- R1: The buffer size is decoded from control bit 3 (extension) and bits 2:1 (code): with the extension clear codes 0..3 give 2048, 1024, 512 and 256 bytes; with it set they give invalid, 16384, 8192 and 4096 bytes.
- R2: A frame that arrives while control bit 0 (enable) is clear or while the decoded size is invalid makes no memory access and leaves the head unchanged, and all of its ceil(len/4) data words are drained.
- R3: When a buffer is needed and head equals tail, ev_overrun pulses for one cycle, the head stays put, no further descriptor is touched and the remaining data words of the frame are drained.
- R4: A descriptor sits at byte address base + 16*head; its word at offset 0 gives bits 31:0 and its word at offset 4 gives bits 63:32 of the buffer address.
- R5: Each buffer receives min(remaining bytes, buffer size) bytes, written as consecutive 32-bit words from the buffer address, with the count rounded up to whole words.
- R6: The length word at descriptor offset 8 is written before the status word at offset 12; it holds the byte count placed in that buffer, plus 4 on the final descriptor of the frame.
- R7: The status word is 0x5 (done, ignore-checksum) on intermediate descriptors and 0x7 (adding end-of-packet) on the final one, and ev_done pulses once per fully stored frame.
- R8: After each descriptor the head increments and wraps to 0 when it reaches ring length / 16; the ring length register (address 2) keeps only the bits selected by 0xFFF80.
- R9: The head (address 3) and tail (address 4) registers keep only the low 16 bits of a write; all registers read 0 after reset.
- R10: Once raised, a memory request stays high with a stable address until it is acknowledged.
- R11: The free-descriptor test uses the tail value held before any tail write landing on the same clock edge; that write counts from the next test on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 base low, 1 base high, 2 ring length, 3 head, 4 tail, 5 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| frm_start | input | 1 | Start of a new frame (accepted when idle) |
| frm_len | input | 16 | Total frame byte count, sampled with frm_start |
| frm_valid | input | 1 | Frame data word valid |
| frm_ready | output | 1 | Frame data word consumed |
| frm_data | input | 32 | Frame data word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack on reads |
| ev_overrun | output | 1 | One-cycle pulse on ring overrun |
| ev_done | output | 1 | One-cycle pulse when a frame is fully stored |
| busy | output | 1 | A frame is being handled |

## Verification
The free-descriptor test and a software write to the tail register can land on the same clock edge. The bench provokes this by starting a frame into a ring whose head equals its tail and writing a larger tail in the very next cycle, so the write reaches the register on the edge where the engine makes its decision. The engine must still report an overrun and leave the head alone, and a second frame sent right after must be stored using the new tail; the same edge-sharing between an engine head advance and a software head write resolves in favour of the software write.

// File: rtl/rx_ring_wb.sv
module rx_ring_wb (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        frm_start,
  input  logic [15:0] frm_len,
  input  logic        frm_valid,
  output logic        frm_ready,
  input  logic [31:0] frm_data,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        ev_overrun,
  output logic        ev_done,
  output logic        busy
);
  localparam logic [2:0] A_BLO = 3'd0, A_BHI = 3'd1, A_LEN = 3'd2,
                         A_HEAD = 3'd3, A_TAIL = 3'd4, A_CTL = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RD0, S_RD1, S_DATA, S_WLEN, S_WSTAT, S_DROP} st_t;
  st_t st;

  logic [63:0] base, buf_addr;
  logic [19:0] rlen;
  logic [15:0] head, tail, rem, len_q, bsize, chunk, head_nxt;
  logic [3:0]  ctl;
  logic [13:0] wcnt, nwords;
  logic [14:0] dcnt;
  logic        last;

  function automatic logic [14:0] words_of(input logic [15:0] n);
    logic [16:0] t;
    t = {1'b0, n} + 17'd3;
    return t[16:2];
  endfunction

  always_comb begin
    case (ctl[3:1])
      3'd0: bsize = 16'd2048;
      3'd1: bsize = 16'd1024;
      3'd2: bsize = 16'd512;
      3'd3: bsize = 16'd256;
      3'd5: bsize = 16'd16384;
      3'd6: bsize = 16'd8192;
      3'd7: bsize = 16'd4096;
      default: bsize = 16'd0;
    endcase
  end

  assign chunk    = (rem > bsize) ? bsize : rem;
  assign nwords   = words_of(chunk)[13:0];
  assign head_nxt = (head + 16'd1 == rlen[19:4]) ? 16'd0 : head + 16'd1;

  wire [63:0] desc_addr = base + {44'd0, head, 4'd0};

  assign busy      = (st != S_IDLE);
  assign mem_we    = (st == S_DATA) || (st == S_WLEN) || (st == S_WSTAT);
  assign mem_req   = (st == S_RD0) || (st == S_RD1) || (st == S_WLEN) || (st == S_WSTAT) ||
                     ((st == S_DATA) && frm_valid);
  assign frm_ready = ((st == S_DATA) && mem_ack) || ((st == S_DROP) && (dcnt != 15'd0));

  always_comb begin
    case (st)
      S_RD1:   mem_addr = desc_addr + 64'd4;
      S_DATA:  mem_addr = buf_addr + {48'd0, wcnt, 2'b00};
      S_WLEN:  mem_addr = desc_addr + 64'd8;
      S_WSTAT: mem_addr = desc_addr + 64'd12;
      default: mem_addr = desc_addr;
    endcase
    case (st)
      S_DATA:  mem_wdata = frm_data;
      S_WLEN:  mem_wdata = {16'd0, len_q + (last ? 16'd4 : 16'd0)};
      S_WSTAT: mem_wdata = {29'd0, 1'b1, last, 1'b1};
      default: mem_wdata = 32'd0;
    endcase
    case (cfg_addr)
      A_BLO:   cfg_rdata = base[31:0];
      A_BHI:   cfg_rdata = base[63:32];
      A_LEN:   cfg_rdata = {12'd0, rlen};
      A_HEAD:  cfg_rdata = {16'd0, head};
      A_TAIL:  cfg_rdata = {16'd0, tail};
      A_CTL:   cfg_rdata = {28'd0, ctl};
      default: cfg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; base <= '0; buf_addr <= '0; rlen <= '0; head <= '0; tail <= '0;
      ctl <= '0; rem <= '0; len_q <= '0; wcnt <= '0; dcnt <= '0; last <= 1'b0;
      ev_overrun <= 1'b0; ev_done <= 1'b0;
    end else begin
      ev_overrun <= 1'b0;
      ev_done    <= 1'b0;
      case (st)
        S_IDLE: if (frm_start) begin
          rem <= frm_len;
          if (!ctl[0] || bsize == 16'd0) begin
            dcnt <= words_of(frm_len);
            st   <= S_DROP;
          end else st <= S_CHECK;
        end
        S_CHECK:
          if (rem == 16'd0) st <= S_IDLE;
          else if (head == tail) begin
            ev_overrun <= 1'b1;
            dcnt       <= words_of(rem);
            st         <= S_DROP;
          end else st <= S_RD0;
        S_RD0: if (mem_ack) begin buf_addr[31:0] <= mem_rdata; st <= S_RD1; end
        S_RD1: if (mem_ack) begin buf_addr[63:32] <= mem_rdata; wcnt <= '0; st <= S_DATA; end
        S_DATA: if (mem_ack) begin
          if (wcnt == nwords - 14'd1) begin
            len_q <= chunk;
            last  <= (rem == chunk);
            rem   <= rem - chunk;
            st    <= S_WLEN;
          end else wcnt <= wcnt + 14'd1;
        end
        S_WLEN:  if (mem_ack) st <= S_WSTAT;
        S_WSTAT: if (mem_ack) begin head <= head_nxt; ev_done <= last; st <= S_CHECK; end
        S_DROP:
          if (dcnt == 15'd0) st <= S_IDLE;
          else if (frm_valid) dcnt <= dcnt - 15'd1;
        default: st <= S_IDLE;
      endcase
      if (cfg_we) begin
        case (cfg_addr)
          A_BLO:  base[31:0]  <= cfg_wdata;
          A_BHI:  base[63:32] <= cfg_wdata;
          A_LEN:  rlen <= cfg_wdata[19:0] & 20'hFFF80;
          A_HEAD: head <= cfg_wdata[15:0];
          A_TAIL: tail <= cfg_wdata[15:0];
          A_CTL:  ctl  <= cfg_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_len_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WSTAT && $past(st) != S_WSTAT) |-> ($past(st) == S_WLEN && $past(mem_ack)));

  assert_one_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_overrun && ev_done));

  assert_head_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (head != $past(head) && !$past(cfg_we && cfg_addr == A_HEAD)) |->
    (head == 16'd0 || head == $past(head) + 16'd1));

  assert_tail_sw_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tail != $past(tail)) |-> $past(cfg_we && cfg_addr == A_TAIL));

  assert_drop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DROP) |-> !mem_req);
endmodule

// File: tb/rx_ring_wb_tb.sv
module rx_ring_wb_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [2:0] cfg_addr = '0; logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic frm_start = 1'b0; logic [15:0] frm_len = '0;
  logic frm_valid, frm_ready; logic [31:0] frm_data;
  logic mem_req, mem_we, mem_ack; logic [63:0] mem_addr; logic [31:0] mem_wdata, mem_rdata;
  logic ev_overrun, ev_done, busy;

  always #10 clk = ~clk;

  rx_ring_wb dut_i (.*);

  int checks = 0, fails = 0;
  logic [31:0] mem [0:4095];
  int seq [0:4095];
  int acc_cnt = 0, viol = 0, done_cnt = 0, ovr_cnt = 0;
  logic ack_q = 1'b0; logic [31:0] rd_q = '0;
  logic pend = 1'b0; logic [63:0] pend_addr = '0;
  int src_words = 0, src_idx = 0; logic [7:0] src_tag = '0;

  assign mem_ack = ack_q;
  assign mem_rdata = rd_q;
  assign frm_valid = src_idx < src_words;
  assign frm_data = {src_tag, 24'(src_idx)};

  always @(posedge clk) begin
    if (mem_req && !ack_q) begin
      ack_q <= 1'b1;
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        seq[mem_addr[13:2]] <= acc_cnt;
      end else rd_q <= mem[mem_addr[13:2]];
    end else ack_q <= 1'b0;
    if (pend && (!mem_req || mem_addr != pend_addr)) viol <= viol + 1;
    pend <= mem_req && !ack_q;
    pend_addr <= mem_addr;
    if (frm_valid && frm_ready) src_idx <= src_idx + 1;
    if (ev_done) done_cnt <= done_cnt + 1;
    if (ev_overrun) ovr_cnt <= ovr_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic fill_ring();
    for (int d = 0; d < 8; d++) begin
      mem[d*4]   = 32'h400 + 32'(d) * 32'h100;
      mem[d*4+1] = 32'd0;
      mem[d*4+2] = 32'hDEAD0000 + 32'(d);
      mem[d*4+3] = 32'hDEAD0000 + 32'(d);
    end
  endtask

  task automatic send(input logic [15:0] len, input logic [7:0] tag, input bit tail_hit, input logic [15:0] tval);
    @(negedge clk);
    src_tag = tag; src_words = (int'(len) + 3) / 4; src_idx = 0;
    frm_start = 1'b1; frm_len = len;
    @(negedge clk); frm_start = 1'b0;
    if (tail_hit) begin cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = {16'd0, tval}; @(negedge clk); cfg_we = 1'b0; end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_desc(input int d, input logic [31:0] l, input logic [31:0] s, input string req);
    chk(mem[d*4+2] == l, {req, " length word"}, mem[d*4+2], l);
    chk(mem[d*4+3] == s, {req, " status word"}, mem[d*4+3], s);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R9 reset register value", v, 0);
    end
    chk(!busy && !mem_req, "R9 idle after reset", {busy, mem_req}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd2, 32'hFFFFFFFF); rd(3'd2, v); chk(v == 32'hFFF80, "R8 length mask", v, 32'hFFF80);
    wr(3'd3, 32'h00012345); rd(3'd3, v); chk(v == 32'h2345, "R9 head low bits", v, 32'h2345);
    wr(3'd4, 32'hABCD6789); rd(3'd4, v); chk(v == 32'h6789, "R9 tail low bits", v, 32'h6789);
  endtask

  task automatic t_basic();
    int bad = 0, d0 = done_cnt; logic [31:0] v;
    fill_ring();
    wr(3'd0, 32'd0); wr(3'd1, 32'd0); wr(3'd2, 32'h80);
    wr(3'd3, 0); wr(3'd4, 7); wr(3'd5, 32'h7);
    send(16'd600, 8'd1, 1'b0, 0);
    chk_desc(0, 256, 5, "R5 R7 first buffer");
    chk_desc(1, 256, 5, "R5 R7 second buffer");
    chk_desc(2, 92, 7, "R6 R7 final buffer");
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < (i < 2 ? 64 : 22); j++)
        if (mem[32'h100 + i*32'h40 + j] != {8'd1, 24'(i*64 + j)}) bad++;
    chk(bad == 0, "R4 R5 data placement", bad, 0);
    chk(mem[32'h100 + 2*32'h40 + 22] == 32'h0BAD0BAD, "R5 no write past rounded count", mem[32'h100+2*32'h40+22], 32'h0BAD0BAD);
    for (int d = 0; d < 3; d++) if (seq[d*4+2] >= seq[d*4+3]) bad++;
    chk(bad == 0, "R6 length before status", bad, 0);
    rd(3'd3, v); chk(v == 3, "R8 head advance", v, 3);
    chk(done_cnt == d0 + 1, "R7 done event", done_cnt, d0 + 1);
  endtask

  task automatic t_sizes();
    int a0; logic [31:0] v;
    fill_ring();
    wr(3'd3, 3); wr(3'd4, 7);
    wr(3'd5, 32'h1); send(16'd1000, 8'd2, 1'b0, 0);
    chk_desc(3, 1004, 7, "R1 2048-byte buffer");
    wr(3'd5, 32'hF); send(16'd4000, 8'd3, 1'b0, 0);
    chk_desc(4, 4004, 7, "R1 4096-byte buffer");
    wr(3'd5, 32'h5); send(16'd600, 8'd4, 1'b0, 0);
    chk_desc(5, 512, 5, "R1 512-byte buffer split");
    chk_desc(6, 92, 7, "R1 512-byte buffer tail");
    a0 = acc_cnt;
    wr(3'd5, 32'h9); send(16'd300, 8'd5, 1'b0, 0);
    chk(acc_cnt == a0, "R2 invalid size no access", acc_cnt, a0);
    chk(src_idx == 75, "R2 invalid size drained", src_idx, 75);
    wr(3'd5, 32'h6); send(16'd301, 8'd6, 1'b0, 0);
    chk(acc_cnt == a0, "R2 disabled no access", acc_cnt, a0);
    chk(src_idx == 76, "R2 disabled drained", src_idx, 76);
    rd(3'd3, v); chk(v == 7, "R2 head unchanged", v, 7);
  endtask

  task automatic t_overrun();
    int o0 = ovr_cnt, d0 = done_cnt; logic [31:0] v;
    fill_ring();
    wr(3'd5, 32'h7); wr(3'd3, 0); wr(3'd4, 2);
    send(16'd600, 8'd7, 1'b0, 0);
    chk_desc(0, 256, 5, "R3 first buffer");
    chk_desc(1, 256, 5, "R3 second buffer");
    chk(mem[10] == 32'hDEAD0002, "R3 next descriptor untouched", mem[10], 32'hDEAD0002);
    rd(3'd3, v); chk(v == 2, "R3 head stops at tail", v, 2);
    chk(ovr_cnt == o0 + 1, "R3 overrun event", ovr_cnt, o0 + 1);
    chk(done_cnt == d0, "R3 no done event", done_cnt, d0);
    chk(src_idx == 150, "R3 rest drained", src_idx, 150);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    fill_ring();
    wr(3'd3, 6); wr(3'd4, 2);
    send(16'd600, 8'd8, 1'b0, 0);
    chk_desc(6, 256, 5, "R8 before wrap");
    chk_desc(7, 256, 5, "R8 last slot");
    chk_desc(0, 92, 7, "R8 wrapped slot");
    rd(3'd3, v); chk(v == 1, "R8 head after wrap", v, 1);
  endtask

  task automatic t_same_edge();
    int o0 = ovr_cnt; logic [31:0] v;
    fill_ring();
    wr(3'd3, 1); wr(3'd4, 1);
    send(16'd100, 8'd9, 1'b1, 16'd3);
    chk(ovr_cnt == o0 + 1, "R11 old tail decides", ovr_cnt, o0 + 1);
    rd(3'd3, v); chk(v == 1, "R11 head held", v, 1);
    rd(3'd4, v); chk(v == 3, "R11 tail write kept", v, 3);
    send(16'd100, 8'd10, 1'b0, 0);
    chk_desc(1, 104, 7, "R11 new tail used");
    rd(3'd3, v); chk(v == 2, "R11 head after frame", v, 2);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin mem[i] = 32'h0BAD0BAD; seq[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_basic();
    t_sizes();
    t_overrun();
    t_wrap();
    t_same_edge();
    chk(viol == 0, "R10 request held until ack", viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=busy expected=idle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule